// File: doc/BRIEF.md
# Serial Result Shifter for a Sampling Converter

This block is the output stage of a 24-bit sampling converter that presents its results over an SPI-style serial link. A counter-based stand-in source produces a fresh 24-bit word at the end of every conversion period. The period is chosen by a two-bit mode input. For each new word the shifter loads its shift register, puts the top bit on the serial output, and then pulls an active-low ready line low. A host answers by toggling a serial clock. After each falling serial-clock edge the output advances by one bit.

Bits that arrive on the serial input are shifted in behind the local word. Several converters can therefore be chained, output to input, and read as one long frame. The serial clock and serial input are sampled in the master-clock domain through a synchroniser. All state changes happen on the rising edge of the master clock.

Top module: `conv_spi_shifter`

## Requirements
- R1: While reset is asserted and until the first result is ready, `drdyN` is 1 and `dout` is 0.
- R2: The k-th result after reset (k = 1, 2, ...) equals (k × 0x9E3779) mod 2^24. It is sent most significant bit first.
- R3: With `modeSel` = 2'b00 (fast), consecutive falls of `drdyN` are 256 master-clock cycles apart. With 2'b01 (fine), 2'b10 (low power) or 2'b11, they are 512 cycles apart.
- R4: A new result's MSB is already on `dout` in the cycle in which `drdyN` falls. `drdyN` falls two master-clock cycles after the internal conversion strobe.
- R5: After each falling edge of `sclk`, `dout` moves to the next bit within three master-clock cycles.
- R6: `drdyN` stays low until the first falling edge of `sclk` after it fell. It returns high in the same cycle that the first shift takes effect.
- R7: `din` is sampled at each falling edge of `sclk`. The bits taken in appear on `dout` in arrival order, directly after the 24 local bits.
- R8: If a result is not read before the next conversion ends, the register reloads with the newer word. `drdyN` is then high for one cycle and falls again.
- R9: Once the 24 local bits have been shifted out while `din` is 0, `dout` stays 0 on further `sclk` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 2 | Operating mode; selects the conversion period |
| sclk | input | 1 | Host serial clock, idle low |
| din | input | 1 | Serial chain input from the next device |
| drdyN | output | 1 | Active-low result-ready flag |
| dout | output | 1 | Serial data output |

## Verification
The assertions assume that `sclk` toggles no faster than half the master-clock rate. This lets the synchroniser see every level of `sclk` for at least one clock edge. They also assume that `din` changes only together with falling `sclk` edges. The bench drives every input on the falling master-clock edge and holds each `sclk` level for two master-clock cycles (one quarter of the clock rate). It starts each read right after `drdyN` falls, so no conversion strobe arrives while a read is in progress unless a test leaves the result unread on purpose.

// File: rtl/conv_spi_pkg.sv
package conv_spi_pkg;

  typedef enum logic [1:0] {
    MODE_FAST   = 2'b00,
    MODE_FINE   = 2'b01,
    MODE_LOWPWR = 2'b10,
    MODE_SPARE  = 2'b11
  } convMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // take a fresh conversion word
    logic shift;    // advance one bit
    logic shiftIn;  // synchronised chain bit for this shift
  } dpStrobe_t;

endpackage

// File: rtl/conv_word_src.sv
module conv_word_src
  import conv_spi_pkg::*;
#(
  parameter int          WORD_W      = 24,
  parameter int          BASE_PERIOD = 256,
  parameter logic [23:0] WORD_STEP   = 24'h9E3779
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        modeSel,
  output logic              convStrobe,
  output logic [WORD_W-1:0] nextWord
);

  localparam int CNT_W = $clog2(2 * BASE_PERIOD);
  localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(BASE_PERIOD - 1);
  localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(2 * BASE_PERIOD - 1);
  localparam logic [WORD_W-1:0] STEP_W = WORD_W'(WORD_STEP);

  logic [CNT_W-1:0]  periodCnt;
  logic [CNT_W-1:0]  lastIdx;
  logic [WORD_W-1:0] wordAcc;

  always_comb begin
    lastIdx    = (convMode_t'(modeSel) == MODE_FAST) ? FAST_LAST : SLOW_LAST;
    convStrobe = (periodCnt >= lastIdx);
    nextWord   = wordAcc + STEP_W;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodCnt <= '0;
      wordAcc   <= '0;
    end else begin
      periodCnt <= convStrobe ? '0 : periodCnt + 1'b1;
      if (convStrobe) wordAcc <= nextWord;
    end
  end

  // R3: a strobe always restarts the period count
  assert_period_restart_R3: assert property (@(posedge clk) disable iff (!rstN)
    convStrobe |=> (periodCnt == '0));

endmodule

// File: rtl/spi_shift_ctrl.sv
module spi_shift_ctrl
  import conv_spi_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclk,
  input  logic      din,
  input  logic      convStrobe,
  output dpStrobe_t strb,
  output logic      drdyN
);

  logic [2:0] sclkSync;
  logic [1:0] dinSync;
  logic       fallSeen;
  logic       armed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkSync <= '0;
      dinSync  <= '0;
    end else begin
      sclkSync <= {sclkSync[1:0], sclk};
      dinSync  <= {dinSync[0], din};
    end
  end

  always_comb begin
    fallSeen     = sclkSync[2] & ~sclkSync[1];
    strb.load    = convStrobe;
    strb.shift   = fallSeen & ~convStrobe;
    strb.shiftIn = dinSync[1];
  end

  // ready sequencing: strobe -> high, next cycle -> low, first fall -> high
  always_ff @(posedge clk) begin
    if (!rstN) begin
      drdyN <= 1'b1;
      armed <= 1'b0;
    end else if (convStrobe) begin
      drdyN <= 1'b1;
      armed <= 1'b1;
    end else if (armed) begin
      drdyN <= 1'b0;
      armed <= 1'b0;
    end else if (fallSeen) begin
      drdyN <= 1'b1;
    end
  end

  assert_ready_after_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    convStrobe |=> ##1 !drdyN);

  assert_reload_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    convStrobe |=> drdyN);

  assert_release_on_fall_R6: assert property (@(posedge clk) disable iff (!rstN)
    (fallSeen && !drdyN && !convStrobe) |=> drdyN);

  assert_ready_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!drdyN && !fallSeen && !convStrobe) |=> !drdyN);

endmodule

// File: rtl/spi_shift_dp.sv
module spi_shift_dp
  import conv_spi_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [WORD_W-1:0] loadWord,
  output logic              dout
);

  logic [WORD_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strb.load) begin
      shiftReg <= loadWord;
    end else if (strb.shift) begin
      shiftReg <= {shiftReg[WORD_W-2:0], strb.shiftIn};
    end
  end

  assign dout = shiftReg[WORD_W-1];

  assert_msb_on_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (dout == $past(loadWord[WORD_W-1])));

  assert_next_bit_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.shift && !strb.load) |=> (dout == $past(shiftReg[WORD_W-2])));

endmodule

// File: rtl/conv_spi_shifter.sv
module conv_spi_shifter
  import conv_spi_pkg::*;
#(
  parameter int          WORD_W      = 24,
  parameter int          BASE_PERIOD = 256,
  parameter logic [23:0] WORD_STEP   = 24'h9E3779
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       sclk,
  input  logic       din,
  output logic       drdyN,
  output logic       dout
);

  logic              convStrobe;
  logic [WORD_W-1:0] nextWord;
  dpStrobe_t         strb;

  conv_word_src #(
    .WORD_W(WORD_W), .BASE_PERIOD(BASE_PERIOD), .WORD_STEP(WORD_STEP)
  ) u_src (
    .clk(clk), .rstN(rstN), .modeSel(modeSel),
    .convStrobe(convStrobe), .nextWord(nextWord)
  );

  spi_shift_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .din(din),
    .convStrobe(convStrobe), .strb(strb), .drdyN(drdyN)
  );

  spi_shift_dp #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .loadWord(nextWord), .dout(dout)
  );

endmodule

// File: tb/conv_spi_shifter_bench.sv
module conv_spi_shifter_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic sclk = 1'b0;
  logic din = 1'b0;
  logic drdyN;
  logic dout;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int cycle = 0;
  int falls = 0;
  int lastFall = 0;
  int lastInterval = 0;
  bit highSeen = 0;
  logic prevDrdy = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_spi_shifter u_conv_spi_shifter (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .sclk(sclk), .din(din),
    .drdyN(drdyN), .dout(dout)
  );

  // ready-line monitor, sampled just after each rising edge
  always @(posedge clk) begin
    #1;
    cycle++;
    if (rstN) begin
      if (prevDrdy && !drdyN) begin
        falls++;
        lastInterval = cycle - lastFall;
        lastFall = cycle;
      end
      if (drdyN) highSeen = 1;
    end
    prevDrdy = drdyN;
  end

  function automatic logic [23:0] wordFor(int k);
    longint p;
    p = longint'(k) * 64'h9E3779;
    return p[23:0];
  endfunction

  task automatic chk(string tag, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitFall();
    int f = falls;
    while (falls == f) @(negedge clk);
  endtask

  // reads n bits; chain input carries chainWord MSB first on the first 24 falls
  task automatic readBits(int n, logic [23:0] chainWord, output logic [47:0] got,
                          output logic drdyBefore, output logic drdyAfter);
    got = '0;
    for (int i = 0; i < n; i++) begin
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      got[n-1-i] = dout;
      if (i == 0) drdyBefore = drdyN;
      if (i == 1) drdyAfter = drdyN;
      din = (i < 24) ? chainWord[23-i] : 1'b0;
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    din = 1'b0;
  endtask

  task automatic test_reset();
    repeat (4) @(negedge clk);
    chk("R1 drdyN in reset", {47'd0, drdyN}, 48'd1);
    chk("R1 dout in reset", {47'd0, dout}, 48'd0);
    rstN = 1'b1;
    repeat (100) @(negedge clk);
    chk("R1 drdyN before first result", {47'd0, drdyN}, 48'd1);
    chk("R1 dout before first result", {47'd0, dout}, 48'd0);
  endtask

  task automatic test_period(logic [1:0] m, int expP);
    modeSel = m;
    waitFall();
    waitFall();
    chk($sformatf("R3 period mode %0d", m), 48'(lastInterval), 48'(expP));
  endtask

  task automatic test_read();
    logic [47:0] got;
    logic b, a;
    int k;
    waitFall();
    k = falls;
    chk("R4 MSB valid at ready fall", {47'd0, dout}, {47'd0, wordFor(k)[23]});
    readBits(24, 24'd0, got, b, a);
    chk("R6 ready held before first fall", {47'd0, b}, 48'd0);
    chk("R6 ready released after first fall", {47'd0, a}, 48'd1);
    chk("R2 R5 word shifted MSB first", got, {24'd0, wordFor(k)});
  endtask

  task automatic test_daisy();
    logic [47:0] got;
    logic b, a;
    int k;
    logic [23:0] chainWord = 24'hA5C31E;
    waitFall();
    k = falls;
    readBits(48, chainWord, got, b, a);
    chk("R7 local word first", {24'd0, got[47:24]}, {24'd0, wordFor(k)});
    chk("R7 chain bits follow", {24'd0, got[23:0]}, {24'd0, chainWord});
  endtask

  task automatic test_tail();
    logic [47:0] got;
    logic b, a;
    int k;
    waitFall();
    k = falls;
    readBits(30, 24'd0, got, b, a);
    chk("R9 local word", {24'd0, got[29:6]}, {24'd0, wordFor(k)});
    chk("R9 zero tail", {42'd0, got[5:0]}, 48'd0);
    chk("R9 dout idle zero", {47'd0, dout}, 48'd0);
  endtask

  task automatic test_overrun();
    logic [47:0] got;
    logic b, a;
    int k;
    waitFall();
    k = falls;
    highSeen = 0;
    waitFall();
    chk("R8 ready pulsed high", {47'd0, highSeen}, 48'd1);
    chk("R8 one new result", 48'(falls), 48'(k + 1));
    chk("R8 MSB of newer word", {47'd0, dout}, {47'd0, wordFor(k + 1)[23]});
    readBits(24, 24'd0, got, b, a);
    chk("R8 newer word read", got, {24'd0, wordFor(k + 1)});
  endtask

  initial begin
    test_reset();
    test_period(2'b00, 256);
    test_read();
    test_period(2'b01, 512);
    test_read();
    test_period(2'b10, 512);
    test_period(2'b11, 512);
    modeSel = 2'b00;
    waitFall();
    test_daisy();
    test_tail();
    test_overrun();
    modeSel = 2'b10;
    waitFall();
    test_read();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule